// File: doc/BRIEF.md
# Clock-Phase-1 SPI Slave Transceiver

This block is the slave end of a four-wire serial link that uses the clock-phase-1 transfer format. It swaps 8-bit frames with a master, most significant bit first in both directions. The serial clock, the data-in line and the active-low select pass through two-flop synchronizers into a faster system clock, and all edge detection happens there. A configuration input sets the clock idle level, so both polarities are handled. A frame opens on the first clock edge seen while selected, not on the select falling edge. This lets the select stay low across any number of consecutive frames.

On the system side, software-facing logic writes the next outgoing byte with a load strobe. The block then returns each completed incoming byte with a one-cycle valid pulse. If a frame opens before any new byte was loaded, the previous byte is sent again and a one-cycle underrun pulse is raised. Raising the select at any point abandons a partial frame.

The control state machine has three states:
- ST_DESEL: not selected.
- ST_AWAIT_LEAD: selected, waiting for a leading edge.
- ST_AWAIT_TRAIL: a leading edge was taken, waiting for the sampling edge.

Its transitions are:
- select_drop: ST_DESEL to ST_AWAIT_LEAD.
- lead_taken: ST_AWAIT_LEAD to ST_AWAIT_TRAIL.
- trail_taken: ST_AWAIT_TRAIL to ST_AWAIT_LEAD.
- abort: any state to ST_DESEL while the synchronized select is high.

Top module: `spi_cpha1_slave`

## Requirements
- R1: After reset, rx_valid and tx_underrun are 0. With ss_n high, miso_oe is 0.
- R2: The eight data-in bits of a frame are sampled on the trailing clock edges, the first sample being bit 7. The received byte appears on rx_data with rx_valid high for exactly one system cycle. That cycle is the third rising system-clock edge after the eighth trailing edge.
- R3: Bit 7-k of the frame's transmit byte is on miso from the third system clock after the (k+1)-th leading edge until the next leading edge is taken.
- R4: miso_oe equals the inverse of ss_n at all times. miso is meant to be driven only while miso_oe is 1.
- R5: With cpol=0 the leading edge is the rising edge of sck. With cpol=1 the idle level is high and the leading edge is the falling edge.
- R6: Frames follow one another with ss_n held low; each group of eight leading/trailing pairs is a new frame.
- R7: ss_n going high mid-frame discards the partial bits and produces no rx_valid. The next frame after reselection is aligned to its own first leading edge.
- R8: A byte loaded with tx_load while ss_n is high is kept and sent in the next frame.
- R9: If a frame opens with no tx_load since the previous frame opened, the last loaded byte is sent again. tx_underrun pulses for one cycle, three system clocks after that frame's first leading edge.
- R10: A frame that opens after a fresh tx_load sends that byte and raises no tx_underrun.
- R11: rx_valid pulses exactly once per completed frame and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the sck rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Clock idle level: 0 low, 1 high |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for miso (1 = drive, 0 = high impedance) |
| tx_data | input | 8 | Next byte to transmit |
| tx_load | input | 1 | Strobe that captures tx_data |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: rx_data updated |
| tx_underrun | output | 1 | One-cycle pulse: frame opened without a fresh byte |

## Verification
The hardest case is an aborted frame followed by a clean one. The select must rise after only some of the bits, with a new byte loaded during deselection. The reselected frame must then show both the new byte and an intact received byte, with no stray valid pulse. The stimulus shifts three bits, raises the select, loads a byte while deselected, and lowers the select again. It then runs a full frame and compares both data directions and the pulse counts. Back-to-back frames with no select toggle, and a frame without a load, reach the resend path. The polarity switch is exercised by raising the select, setting the clock idle level high, and repeating the exchange.

// File: rtl/spi_cpha1_pkg.sv
package spi_cpha1_pkg;

    typedef enum logic [1:0] {
        ST_DESEL       = 2'd0,
        ST_AWAIT_LEAD  = 2'd1,
        ST_AWAIT_TRAIL = 2'd2
    } link_state_e;

endpackage

// File: rtl/spi_sync_bank.sv
module spi_sync_bank #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_clk_edges.sv
module spi_clk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cpol,
    output logic lead,
    output logic trail
);
    logic norm, norm_q;

    assign norm = sck_s ^ cpol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) norm_q <= 1'b0;
        else        norm_q <= norm;
    end

    assign lead  = norm & ~norm_q;
    assign trail = ~norm & norm_q;
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FRAME_BITS-1:0] tx_hold,
    input  logic                  frame_start,
    input  logic                  shift_next,
    input  logic                  sample,
    input  logic                  frame_end,
    input  logic                  mosi_s,
    output logic                  miso_bit,
    output logic [FRAME_BITS-1:0] rx_byte,
    output logic                  rx_strobe
);
    logic [FRAME_BITS-1:0] tx_sh;
    logic [FRAME_BITS-1:0] rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (frame_start) begin
            tx_sh <= tx_hold;
        end else if (shift_next) begin
            tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            rx_byte   <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (sample) begin
                rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi_s};
                if (frame_end) begin
                    rx_byte   <= {rx_sh[FRAME_BITS-2:0], mosi_s};
                    rx_strobe <= 1'b1;
                end
            end
        end
    end

    assign miso_bit = tx_sh[FRAME_BITS-1];

    // R3: outgoing bit changes only in the cycle after a taken leading edge
    assert_miso_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start || shift_next) |=> $stable(miso_bit));
endmodule

// File: rtl/spi_cpha1_slave.sv
module spi_cpha1_slave
    import spi_cpha1_pkg::*;
#(
    parameter int FRAME_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpol,
    input  logic                  sck,
    input  logic                  mosi,
    input  logic                  ss_n,
    output logic                  miso,
    output logic                  miso_oe,
    input  logic [FRAME_BITS-1:0] tx_data,
    input  logic                  tx_load,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  rx_valid,
    output logic                  tx_underrun
);
    localparam int                CNT_W    = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic sck_s, mosi_s, ss_s;
    logic lead, trail;

    spi_sync_bank #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n, mosi, sck}),
        .q     ({ss_s, mosi_s, sck_s})
    );

    spi_clk_edges u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_s (sck_s),
        .cpol  (cpol),
        .lead  (lead),
        .trail (trail)
    );

    link_state_e      state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic             frame_start, shift_next, sample, frame_end;
    logic [FRAME_BITS-1:0] tx_hold;
    logic             fresh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DESEL;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (ss_s) begin
            state_nx = ST_DESEL;                         // abort
        end else begin
            unique case (state)
                ST_DESEL:       state_nx = ST_AWAIT_LEAD;                       // select_drop
                ST_AWAIT_LEAD:  if (lead)  state_nx = ST_AWAIT_TRAIL;           // lead_taken
                ST_AWAIT_TRAIL: if (trail) state_nx = ST_AWAIT_LEAD;            // trail_taken
                default:        state_nx = ST_DESEL;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        frame_start = 1'b0;
        shift_next  = 1'b0;
        sample      = 1'b0;
        frame_end   = 1'b0;
        if (!ss_s) begin
            unique case (state)
                ST_AWAIT_LEAD: begin
                    frame_start = lead && (bit_cnt == '0);
                    shift_next  = lead && (bit_cnt != '0);
                end
                ST_AWAIT_TRAIL: begin
                    sample    = trail;
                    frame_end = trail && (bit_cnt == LAST_BIT);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_cnt <= '0;
        else if (ss_s)   bit_cnt <= '0;
        else if (sample) bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold     <= '0;
            fresh       <= 1'b0;
            tx_underrun <= 1'b0;
        end else begin
            tx_underrun <= frame_start && !fresh;
            if (tx_load)          fresh <= 1'b1;
            else if (frame_start) fresh <= 1'b0;
            if (tx_load) tx_hold <= tx_data;
        end
    end

    spi_shift_path #(.FRAME_BITS(FRAME_BITS)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_hold     (tx_hold),
        .frame_start (frame_start),
        .shift_next  (shift_next),
        .sample      (sample),
        .frame_end   (frame_end),
        .mosi_s      (mosi_s),
        .miso_bit    (miso),
        .rx_byte     (rx_data),
        .rx_strobe   (rx_valid)
    );

    assign miso_oe = !ss_n;

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_underrun_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |=> !tx_underrun);

    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DESEL) |-> (bit_cnt == '0));

    assert_valid_after_trail_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state == ST_AWAIT_TRAIL));
endmodule

// File: tb/tb_spi_cpha1_slave.sv
module tb_spi_cpha1_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       ss_n = 1'b1;
    logic       miso, miso_oe;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, tx_underrun;

    int checks = 0;
    int fails  = 0;
    int valid_seen = 0;
    int ur_seen    = 0;
    int oe_bad     = 0;
    int frames_done = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_cpha1_slave dut (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .sck(sck), .mosi(mosi),
        .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe), .tx_data(tx_data),
        .tx_load(tx_load), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_underrun(tx_underrun)
    );

    // per-clock monitor: enable follows select, pulse counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (miso_oe !== !ss_n) oe_bad++;
            if (rx_valid === 1'b1) valid_seen++;
            if (tx_underrun === 1'b1) ur_seen++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] b);
        @(negedge clk);
        tx_data = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic select(input logic lvl);
        @(negedge clk);
        ss_n = lvl;
        repeat (5) @(negedge clk);
    endtask

    // nbits leading/trailing pairs, sck half period = 4 system clocks
    task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi,
                        input int nbits, input logic exp_ur, input bit chk);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sck  = ~cpol;
            mosi = mo[7-i];
            repeat (3) @(negedge clk);
            if (chk && i == 0) check("R9/R10 underrun pulse", tx_underrun, exp_ur);
            @(negedge clk);
            if (chk) check("R3 miso bit", miso, exp_mi[7-i]);
            sck = cpol;
            if (chk && i == nbits - 1) begin
                repeat (3) @(negedge clk);
                check("R2 rx_valid high", rx_valid, 1);
                check("R2 rx_data", rx_data, mo);
                @(negedge clk);
                check("R2 rx_valid one cycle", rx_valid, 0);
                frames_done++;
            end else begin
                repeat (4) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rx_valid reset", rx_valid, 0);
        check("R1 underrun reset", tx_underrun, 0);
        check("R1 miso_oe deselected", miso_oe, 0);

        // cpol=0, fresh byte (R5, R10)
        load(8'hA5);
        select(1'b0);
        check("R4 miso_oe selected", miso_oe, 1);
        xfer(8'h3C, 8'hA5, 8, 1'b0, 1);

        // back-to-back, select held low (R6)
        load(8'h5A);
        xfer(8'hC3, 8'h5A, 8, 1'b0, 1);
        // no load: resend with underrun (R9)
        xfer(8'h81, 8'h5A, 8, 1'b1, 1);
        check("R9 underrun count", ur_seen, 1);

        // abort after three bits (R7)
        load(8'h96);
        xfer(8'hFF, 8'h96, 3, 1'b0, 0);
        select(1'b1);
        check("R4 miso_oe after abort", miso_oe, 0);
        check("R7 no valid on partial frame", valid_seen, frames_done);
        // load while deselected is kept (R8)
        load(8'h0F);
        repeat (6) @(negedge clk);
        select(1'b0);
        xfer(8'hE7, 8'h0F, 8, 1'b0, 1);   // R7 realignment, R8 held byte

        // cpol=1 (R5)
        select(1'b1);
        @(negedge clk);
        cpol = 1'b1;
        sck  = 1'b1;
        repeat (6) @(negedge clk);
        load(8'h6B);
        select(1'b0);
        xfer(8'h1E, 8'h6B, 8, 1'b0, 1);
        load(8'hF0);
        xfer(8'h0F, 8'hF0, 8, 1'b0, 1);   // R5 and R6 with high idle level
        select(1'b1);

        check("R11 one valid per frame", valid_seen, frames_done);
        check("R9 total underruns", ur_seen, 1);
        check("R4 miso_oe tracking", oe_bad, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule